// File: doc/BRIEF.md
# Fill-Threshold Offload Controller for a Byte Store

This block sits between a byte producer and a large single-port store. Every byte the producer offers through a valid/ready handshake is written to the store at the next sequential address in the same cycle it is accepted. Addresses wrap around the store, so the store behaves as a circular buffer of `2**ADDR_W` bytes.

When the number of stored but not yet fetched bytes reaches a fill threshold (80 percent of capacity by default), the controller starts draining the store by itself. It reads one byte at a time and presents it on an output register with an availability flag that a host polls. The host takes the byte with a one-cycle acknowledge, and the controller then fetches the next one.

Capture never pauses during a drain. A write always wins the shared memory port in a cycle where both want it. The drain ends once the store is empty and no byte is held or in flight. If the store fills completely, further bytes are refused and a sticky overflow flag is raised until reset.

Top module: `offl_ctrl`

## Requirements
- R1: A byte is accepted in a cycle where `in_valid` and `in_ready` are both high. In that same cycle `mem_we` is high, `mem_wdata` equals `in_data`, and `mem_addr` is the count of earlier accepted bytes modulo `2**ADDR_W`.
- R2: `occupancy` equals the number of accepted bytes minus the number of memory reads issued. It ranges from 0 to `2**ADDR_W`.
- R3: `in_ready` is low exactly when `occupancy` equals `2**ADDR_W`. A byte offered while `in_ready` is low is not written, and `overflow` becomes 1 in the next cycle and stays 1 until reset.
- R4: Draining starts with no command. `offload_active` rises in the cycle after one in which it was low and `occupancy` was at least `THRESH = floor(2**ADDR_W * FILL_PCT / 100)`.
- R5: A read (`mem_re` high, `mem_addr` = count of earlier reads modulo `2**ADDR_W`) is issued only when all of these hold: `offload_active` is high, `occupancy` is non-zero, no byte is held on the output or in flight, and no byte is written in that cycle. The store answers one cycle after the read. The byte appears with `out_avail` high two cycles after the read.
- R6: While `out_avail` is high and `host_ack` is low, `out_avail` and `out_data` hold. A `host_ack` with `out_avail` high clears `out_avail` in the next cycle. A `host_ack` with `out_avail` low has no effect.
- R7: Bytes reach `out_data` in the order they were accepted.
- R8: Bytes keep being accepted and written while `offload_active` is high. A write takes the memory port over a read in the same cycle.
- R9: While draining, once `occupancy` is 0 and no byte is held or in flight, `offload_active` falls in the next cycle.
- R10: After a synchronous reset, `occupancy` is 0, `in_ready` is 1, and `out_avail`, `offload_active` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a byte |
| in_data | input | DATA_W | Offered byte |
| in_ready | output | 1 | Store can accept a byte |
| mem_we | output | 1 | Store write strobe |
| mem_re | output | 1 | Store read strobe |
| mem_addr | output | ADDR_W | Store address for the write or read |
| mem_wdata | output | DATA_W | Byte to write |
| mem_rdata | input | DATA_W | Store read data, one cycle after `mem_re` |
| out_avail | output | 1 | A byte waits on `out_data` for the host |
| out_data | output | DATA_W | Byte offered to the host |
| host_ack | input | 1 | Host has taken the byte |
| occupancy | output | ADDR_W+1 | Bytes stored and not yet fetched |
| offload_active | output | 1 | Drain in progress |
| overflow | output | 1 | Sticky: a byte was refused when full |

## Verification
The bench first feeds a burst that stops one byte short of the threshold and then adds the byte that crosses it. This separates an early start from a correct one. Sparse writes during a drain, with a host that acknowledges at once, show that writes and reads interleave with writes winning. A slow host that waits several cycles before acknowledging shows that the output holds and no byte is lost or repeated. A final unbroken burst starves reads behind writes until the store is full, then offers one more byte to show the refusal and the sticky flag. A second reset clears that flag.

// File: rtl/offl_pkg.sv
package offl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } off_st_t;
endpackage

// File: rtl/offl_ptrs.sv
// Write/read pointer pair; occupancy is their difference (R2), full blocks writes (R3).
module offl_ptrs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic              rd_fire,
  input  logic              refuse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   count,
  output logic              full,
  output logic              overflow
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W:0] DEPTH_C = (ADDR_W+1)'(DEPTH);

  logic [ADDR_W:0] wr_q, rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= '0;
      rd_q     <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_fire) wr_q <= wr_q + 1'b1;
      if (rd_fire) rd_q <= rd_q + 1'b1;
      if (refuse)  overflow <= 1'b1;
    end
  end

  assign count   = wr_q - rd_q;
  assign full    = (count == DEPTH_C);
  assign wr_addr = wr_q[ADDR_W-1:0];
  assign rd_addr = rd_q[ADDR_W-1:0];
endmodule

// File: rtl/offl_outreg.sv
// Output holding stage: one read in flight, one byte held for the host (R5, R6).
module offl_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              host_ack,
  output logic              out_avail,
  output logic [DATA_W-1:0] out_data,
  output logic              busy
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      out_avail <= 1'b0;
      out_data  <= '0;
    end else begin
      pend_q <= rd_fire;
      if (pend_q) begin
        out_avail <= 1'b1;
        out_data  <= mem_rdata;
      end else if (out_avail && host_ack) begin
        out_avail <= 1'b0;
      end
    end
  end

  assign busy = pend_q | out_avail;
endmodule

// File: rtl/offl_fsm.sv
// Drain sequencer: starts at the fill threshold (R4), stops when empty (R9),
// and yields the memory port to writes (R8).
module offl_fsm
  import offl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int THRESH = 51
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ADDR_W:0] count,
  input  logic            wr_fire,
  input  logic            busy,
  output logic            active,
  output logic            rd_fire
);
  localparam logic [ADDR_W:0] THR_C = (ADDR_W+1)'(THRESH);

  off_st_t st_q, st_d;
  logic    empty;

  assign empty = (count == '0);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (count >= THR_C) st_d = ST_RUN;
      ST_RUN:  if (empty && !busy) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign active  = (st_q == ST_RUN);
  assign rd_fire = active && !busy && !empty && !wr_fire;
endmodule

// File: rtl/offl_ctrl.sv
module offl_ctrl #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int FILL_PCT = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_avail,
  output logic [DATA_W-1:0] out_data,
  input  logic              host_ack,
  output logic [ADDR_W:0]   occupancy,
  output logic              offload_active,
  output logic              overflow
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int THRESH = (DEPTH * FILL_PCT) / 100;

  logic              full, wr_fire, rd_fire, busy;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign in_ready = !full;
  assign wr_fire  = in_valid && !full;   // R1

  offl_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .refuse   (in_valid && full),        // R3
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .count    (occupancy),
    .full     (full),
    .overflow (overflow)
  );

  offl_fsm #(.ADDR_W(ADDR_W), .THRESH(THRESH)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .count   (occupancy),
    .wr_fire (wr_fire),
    .busy    (busy),
    .active  (offload_active),
    .rd_fire (rd_fire)
  );

  offl_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .rd_fire   (rd_fire),
    .mem_rdata (mem_rdata),
    .host_ack  (host_ack),
    .out_avail (out_avail),
    .out_data  (out_data),
    .busy      (busy)
  );

  // Single shared port: write address wins when both are requested (R8).
  assign mem_we    = wr_fire;
  assign mem_re    = rd_fire;
  assign mem_addr  = wr_fire ? wr_addr : rd_addr;
  assign mem_wdata = in_data;
endmodule

// File: rtl/offl_ctrl_chk.sv
module offl_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int FILL_PCT = 80
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              mem_we,
  input logic              mem_re,
  input logic              out_avail,
  input logic [DATA_W-1:0] out_data,
  input logic              host_ack,
  input logic [ADDR_W:0]   occupancy,
  input logic              offload_active,
  input logic              overflow
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int THRESH = (DEPTH * FILL_PCT) / 100;
  localparam logic [ADDR_W:0] THR_C = (ADDR_W+1)'(THRESH);
  localparam logic [ADDR_W:0] DEP_C = (ADDR_W+1)'(DEPTH);

  p_no_write_full_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (occupancy != DEP_C));

  p_refuse_flags_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> overflow);

  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  p_auto_start_r4: assert property (@(posedge clk) disable iff (rst)
    (!offload_active && occupancy >= THR_C) |=> offload_active);

  p_read_when_active_r5: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (offload_active && occupancy != '0 && !out_avail));

  p_hold_byte_r6: assert property (@(posedge clk) disable iff (rst)
    (out_avail && !host_ack) |=> (out_avail && $stable(out_data)));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mem_re);

  p_occ_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!mem_we && !mem_re) |=> $stable(occupancy));
endmodule

bind offl_ctrl offl_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILL_PCT(FILL_PCT)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .mem_we         (mem_we),
  .mem_re         (mem_re),
  .out_avail      (out_avail),
  .out_data       (out_data),
  .host_ack       (host_ack),
  .occupancy      (occupancy),
  .offload_active (offload_active),
  .overflow       (overflow)
);

// File: tb/offl_ctrl_bench.sv
module offl_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int THRESH = (DEPTH * 80) / 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic host_ack = 1'b0;
  logic in_ready, mem_we, mem_re, out_avail, offload_active, overflow;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata, out_data;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [ADDR_W:0] occupancy;

  always #(CLK_PERIOD/2) clk = ~clk;

  offl_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FILL_PCT(80)) u_offl_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .out_avail(out_avail), .out_data(out_data), .host_ack(host_ack),
    .occupancy(occupancy), .offload_active(offload_active), .overflow(overflow)
  );

  // Behavioural store with one-cycle read latency.
  logic [DATA_W-1:0] store [DEPTH];
  always @(posedge clk) begin
    if (mem_we) store[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= store[mem_addr];
  end

  // Reference model
  byte unsigned q[$];
  int  m_wr, m_rd, wr_in_drain;
  bit  m_act, m_pend, m_avail, m_ovf;
  byte unsigned m_pdata, m_data;

  int n_chk = 0, n_fail = 0;
  int hold_cnt = 0, ack_mode = 0, seed = 0;
  bit done = 0;

  function automatic bit exp_wr();
    return in_valid && (q.size() < DEPTH);
  endfunction
  function automatic bit exp_iss(bit wr);
    return m_act && !m_pend && !m_avail && (q.size() > 0) && !wr;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_wr = 0; m_rd = 0; m_act = 0; m_pend = 0; m_avail = 0; m_ovf = 0;
      m_data = 0; m_pdata = 0;
    end else begin
      bit wr, iss, nact;
      wr  = exp_wr();
      iss = exp_iss(wr);
      if (!m_act) nact = (q.size() >= THRESH);
      else        nact = !(q.size() == 0 && !m_pend && !m_avail);
      if (in_valid && !wr) m_ovf = 1;
      if (m_pend) begin m_avail = 1; m_data = m_pdata; end
      else if (m_avail && host_ack) m_avail = 0;
      m_pend = iss;
      if (iss) begin m_pdata = q.pop_front(); m_rd++; end
      if (wr) begin
        q.push_back(in_data); m_wr++;
        if (m_act) wr_in_drain++;
      end
      m_act = nact;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_regs();
    chk(in_ready == (q.size() < DEPTH), "R3", "in_ready", in_ready, q.size() < DEPTH);
    chk(occupancy == q.size(), "R2", "occupancy", occupancy, q.size());
    chk(offload_active == m_act, "R4/R9", "offload_active", offload_active, m_act);
    chk(out_avail == m_avail, "R6", "out_avail", out_avail, m_avail);
    if (m_avail) chk(out_data == m_data, "R7", "out_data", out_data, m_data);
    chk(overflow == m_ovf, "R3", "overflow", overflow, m_ovf);
  endtask

  task automatic cmp_comb();
    bit wr, iss;
    wr  = exp_wr();
    iss = exp_iss(wr);
    chk(mem_we == wr, "R1", "mem_we", mem_we, wr);
    if (wr) begin
      chk(mem_addr == m_wr % DEPTH, "R1", "write addr", mem_addr, m_wr % DEPTH);
      chk(mem_wdata == in_data, "R1", "write data", mem_wdata, in_data);
    end
    chk(mem_re == iss, "R5", "mem_re", mem_re, iss);
    if (iss) chk(mem_addr == m_rd % DEPTH, "R5", "read addr", mem_addr, m_rd % DEPTH);
    if (wr && m_act) chk(!mem_re, "R8", "read during write", mem_re, 0);
  endtask

  task automatic step(bit v);
    @(negedge clk);
    cmp_regs();
    in_valid = v;
    if (v) begin seed++; in_data = DATA_W'(seed * 37 + 5); end
    if (m_avail) begin
      hold_cnt++;
      host_ack = (ack_mode == 0) || (hold_cnt >= 5);
    end else begin
      hold_cnt = 0;
      host_ack = (seed % 3 == 0);   // ack with nothing held: R6 says no effect
    end
    #1;
    cmp_comb();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; host_ack = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(occupancy == 0, "R10", "reset occupancy", occupancy, 0);
    chk(in_ready == 1, "R10", "reset in_ready", in_ready, 1);
    chk(out_avail == 0, "R10", "reset out_avail", out_avail, 0);
    chk(offload_active == 0, "R10", "reset offload_active", offload_active, 0);
    chk(overflow == 0, "R10", "reset overflow", overflow, 0);
  endtask

  initial begin
    do_reset();
    // Phase A: just below the threshold, then cross it (R4)
    ack_mode = 0;
    for (int i = 0; i < THRESH - 1; i++) step(1);
    step(0); step(0); step(0);
    chk(offload_active == 0, "R4", "idle below threshold", offload_active, 0);
    step(1); step(0); step(0);
    chk(offload_active == 1, "R4", "started at threshold", offload_active, 1);
    for (int i = 0; i < 40; i++) step(i % 4 == 0);
    chk(wr_in_drain > 0, "R8", "writes during drain", wr_in_drain, 1);
    for (int i = 0; i < 80; i++) step(0);
    chk(offload_active == 0 && occupancy == 0, "R9", "drain ended", offload_active, 0);
    // Phase B: slow host (R6)
    ack_mode = 1;
    for (int i = 0; i < THRESH + 2; i++) step(1);
    for (int i = 0; i < 120; i++) step(i % 8 == 0);
    for (int i = 0; i < 200; i++) step(0);
    chk(offload_active == 0, "R9", "slow-host drain ended", offload_active, 0);
    chk(overflow == 0, "R3", "no overflow yet", overflow, 0);
    // Phase C: unbroken burst fills the store, reads starve (R8), refusal (R3)
    ack_mode = 0;
    for (int i = 0; i < DEPTH + 3; i++) step(1);
    step(0);
    chk(occupancy == DEPTH, "R3", "full occupancy", occupancy, DEPTH);
    chk(overflow == 1, "R3", "overflow latched", overflow, 1);
    for (int i = 0; i < 80; i++) step(0);
    chk(overflow == 1, "R3", "overflow sticky", overflow, 1);
    chk(occupancy == 0, "R2", "drained after full", occupancy, 0);
    // Phase D: reset clears everything (R10)
    do_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule